// File: doc/BRIEF.md
# Programmable-Width Frame Pulse Generator

This block divides a fast reference clock (155.52 MHz in the intended use) down to a low-rate frame or timing pulse, such as 8 kHz or 2 kHz. A free-running period counter counts reference cycles and wraps once per frame. The divide ratio is a parameter, so the same design serves both rates: 19440 cycles for 8 kHz and 77760 cycles for 2 kHz.

A 6-bit mode code sets the shape of the output. Code 0 turns the output off. Codes 1 to 62 give a pulse whose high time is that many reference cycles, roughly 6.43 ns to 399 ns at 155.52 MHz. Code 63 gives a square wave with 50% duty cycle at the frame rate. The mode code is sampled only on the last cycle of a frame, so a change never shortens or splits a pulse. Turning the output off does not stop the counter, so a later enable keeps the original frame phase. The output comes straight from a flop.

Top module: `frame_pulse_gen`

## Requirements
- R1: While `rst` is high, on the clock edge the counter goes to 0, the active mode becomes 63, and `frame_o` goes low. After `rst` is released the counter reads 1 on the first edge, and `frame_o` follows the 50% rule from that point.
- R2: The counter runs from 0 to RATIO-1 and then wraps to 0, which gives one frame every RATIO reference cycles. Whenever the active mode is not 0, `frame_o` is high in the cycle in which the counter reads 0.
- R3: When the active mode is 0, `frame_o` stays low. The counter keeps running, so a later enable produces pulses at the same frame phase.
- R4: When the active mode is a code m from 1 to 62, `frame_o` is high exactly while the counter is below m. This gives m reference cycles high in each frame. RATIO must be greater than 62.
- R5: When the active mode is 63, `frame_o` is high exactly while the counter is below RATIO/2 (integer division).
- R6: `mode_i` is sampled only on the edge on which the counter wraps from RATIO-1 to 0. A change at any other time has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 6 | Mode code: 0 off, 1..62 pulse width in cycles, 63 half duty |
| frame_o | output | 1 | Registered frame pulse |

## Verification
The bench runs directed frames with the narrowest width (1), the widest width (62), the half-duty code and the off code. These show the width comparison apart from the RATIO/2 threshold and from forced-low output. A long off stretch followed by an enable shows whether the frame phase survived the disabled frames. Changes to the mode in the middle of a frame and right at the wrap edge show whether the code is taken only at the frame boundary. Random codes held for random spans then mix all of these cases against a cycle-by-cycle reference.

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen #(
  parameter int RATIO = 19440,
  parameter int MW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mode_i,
  output logic          frame_o
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] HALF = CW'(RATIO / 2);
  localparam logic [MW-1:0] M_OFF  = '0;
  localparam logic [MW-1:0] M_HALF = '1;

  logic [CW-1:0] cnt, cnt_nx;
  logic [MW-1:0] mode_q, mode_nx;
  logic          wrap, out_nx;

  assign wrap    = (cnt == LAST);
  assign cnt_nx  = wrap ? '0 : cnt + 1'b1;
  assign mode_nx = wrap ? mode_i : mode_q;

  always_comb begin
    if (mode_nx == M_OFF)       out_nx = 1'b0;
    else if (mode_nx == M_HALF) out_nx = (cnt_nx < HALF);
    else                        out_nx = (cnt_nx < CW'(mode_nx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      mode_q  <= M_HALF;
      frame_o <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      mode_q  <= mode_nx;
      frame_o <= out_nx;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !frame_o);
  p_reset_mode_r1: assert property (@(posedge clk) rst |=> (mode_q == M_HALF && cnt == '0));
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst) wrap |=> cnt == '0);
  p_in_range_r2: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  p_frame_start_r2: assert property (@(posedge clk) disable iff (rst)
    (wrap && mode_i != M_OFF) |=> frame_o);
  p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
    (wrap && mode_i == M_OFF) |=> !frame_o);
  p_width_end_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q != M_OFF && mode_q != M_HALF && !wrap && CW'(mode_q) == cnt + 1'b1) |=> !frame_o);
  p_half_end_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_HALF && !wrap && cnt + 1'b1 == HALF) |=> !frame_o);
  p_hold_mode_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mode_q));
endmodule

// File: tb/test_frame_pulse_gen.sv
module test_frame_pulse_gen;
  localparam int CLK_P = 10;
  localparam int R = 80;

  logic clk = 1'b0, rst = 1'b1, frame_o;
  logic [5:0] mode_i = 6'd63;
  int checks = 0, errors = 0;
  int c = 0, code = 63;
  bit in_rst = 1, changed = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_pulse_gen #(.RATIO(R), .MW(6)) i_frame_pulse_gen (
    .clk(clk), .rst(rst), .mode_i(mode_i), .frame_o(frame_o));

  function automatic bit exp_out(int cc, int m);
    if (m == 0) return 1'b0;
    if (m == 63) return cc < R/2;
    return cc < m;
  endfunction

  task automatic step(input logic r, input int m);
    string tag;
    bit e;
    @(negedge clk);
    rst = r;
    mode_i = 6'(m);
    @(posedge clk);
    if (r) begin
      c = 0; code = 63; in_rst = 1; changed = 0;
    end else begin
      if (c == R-1) begin c = 0; code = m; changed = 0; end
      else begin c++; if (m != code) changed = 1; end
      in_rst = 0;
    end
    #1;
    e = in_rst ? 1'b0 : exp_out(c, code);
    if (in_rst) tag = "R1";
    else if (changed) tag = "R6";
    else if (c == 0) tag = "R2";
    else if (code == 0) tag = "R3";
    else if (code == 63) tag = "R5";
    else tag = "R4";
    checks++;
    if (frame_o !== e) begin
      errors++;
      $display("FAIL %s cnt=%0d mode=%0d actual=%b expected=%b", tag, c, code, frame_o, e);
    end
  endtask

  task automatic frames(input int m, input int n);
    for (int i = 0; i < n * R; i++) step(1'b0, m);
  endtask

  initial begin
    int s;
    s = $urandom(1234);
    for (int i = 0; i < 3; i++) step(1'b1, 5);
    frames(63, 2);
    frames(1, 2);
    frames(62, 2);
    frames(0, 3);
    frames(63, 1);
    for (int i = 0; i < R/3; i++) step(1'b0, 63);
    frames(7, 2);
    for (int i = 0; i < R/2; i++) step(1'b0, 20);
    step(1'b0, 0);
    frames(20, 2);
    for (int i = 0; i < 5; i++) step(1'b1, 3);
    frames(63, 1);
    for (int k = 0; k < 60; k++) begin
      int m, len;
      m = $urandom_range(0, 7) == 0 ? 0 : ($urandom_range(0, 5) == 0 ? 63 : $urandom_range(1, 62));
      len = $urandom_range(1, 3 * R);
      for (int i = 0; i < len; i++) step(1'b0, m);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule